// File: doc/BRIEF.md
# Multi-format serial audio receive port

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a frame clock and a data line. It works as a link slave, so both clocks come from the far end. It recognises four framings: I2S, left-justified, right-justified, and a DSP-style short frame-sync format with A and B variants. It captures word lengths of 16, 20 or 24 bits. It returns the left and right samples as 24-bit words, MSB-aligned, with a one-cycle strobe. Everything runs in the bit-clock domain.

A static 6-bit control input chooses the framing, the word length, the active bit-clock edge and a frame-clock option. In the non-DSP framings that option swaps which frame-clock level means left. In DSP framing it chooses between the A and B variants.

The port also watches the frame length. When a frame carries exactly 32 bit clocks, it drops to 16-bit capture, whatever word length is programmed. The control word is only changed while the port is held in reset.

Top module: `aud_ser_rx`

## Requirements
- R1: `cfg[1:0]` selects the framing: 2'b10 is I2S, 2'b01 is left-justified, 2'b00 is right-justified and 2'b11 is DSP. In I2S the MSB arrives one bit clock after each frame-clock transition. The left channel is the half with the frame clock low, unless R7 inverts it.
- R2: In left-justified framing the MSB arrives in the first bit clock after a frame-clock transition. The left channel is the half with the frame clock high, unless R7 inverts it.
- R3: In right-justified framing the LSB of each word sits in the last bit clock before the next frame-clock transition. The left channel is the half with the frame clock high.
- R4: In DSP framing a one-bit-clock high pulse on the frame clock marks the frame. With `cfg[5]`=0 (variant A) the left MSB follows the pulse by one bit clock. With `cfg[5]`=1 (variant B) it arrives in the pulse's own bit clock. The right word follows the left word's LSB immediately.
- R5: `cfg[3:2]` selects the word length: 2'b00 gives 16 bits, 2'b01 gives 20 bits, and both 2'b10 and 2'b11 give 24 bits. Captured words are MSB-first, left-aligned in bits 23 down to 24-N of the output, and zero below.
- R6: With `cfg[4]`=0 the port samples on the rising bit-clock edge. With `cfg[4]`=1 it samples on the falling edge.
- R7: In the I2S, left-justified and right-justified framings, `cfg[5]`=1 swaps which frame-clock level carries the left channel.
- R8: When a frame holds exactly 32 bit clocks, the port captures 16-bit words whatever `cfg[3:2]` programs. In I2S, left-justified and right-justified framing this means two halves of 16. In DSP framing it means 32 bit clocks from pulse to pulse. In DSP framing the change takes effect from the frame after the first 32-clock frame is measured.
- R9: 24-bit I2S capture works for any frame whose two halves each last at least 24 bit clocks.
- R10: `word_valid` is high for exactly one sampling cycle after a left and right pair of one frame has been captured. The words change only on that cycle.
- R11: While `rst_n` is low, and until the first pair completes, both words read zero and `word_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock from the link master |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 6 | Control word: [1:0] framing, [3:2] word length, [4] sampling edge, [5] frame-clock option |
| fclk | input | 1 | Frame clock or frame-sync pulse |
| sdata | input | 1 | Serial data, MSB first |
| left_word | output | 24 | Last captured left sample, left-aligned |
| right_word | output | 24 | Last captured right sample, left-aligned |
| word_valid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
Each internal fault has its own symptom at the ports.

- A slot counter or delayed phase that is off by one shifts every captured word by one bit. This is visible in the first pair after lock, about two frames after reset.
- A stale half-length or frame-length record makes the port mask to the wrong width in the low bits. The 32-clock frames show this.
- A lost left-pending flag either drops strobes or pairs samples from different frames. This shows up within a frame or two as missing or mismatched pairs.
- A wrong sampling edge scrambles every word.

// File: rtl/aud_rx_pkg.sv
`timescale 1ns/1ps
package aud_rx_pkg;

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_I2S = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    // word length code to bit count; codes 2 and 3 both mean 24
    function automatic int code_to_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/aud_rx_framer.sv
`timescale 1ns/1ps
module aud_rx_framer
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_e             fmt,
    input  logic             alt,
    input  logic             fclk,
    output logic             start,
    output logic [CNT_W-1:0] pos,
    output logic             locked,
    output logic             end_ok,
    output logic             end_left,
    output logic             end_short,
    output logic             frame32
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LEN16   = CNT_W'(16);
    localparam logic [CNT_W-1:0] LEN32   = CNT_W'(32);

    typedef struct packed {
        logic [1:0]       prime;
        logic             dly;
        logic             prev;
        logic             seen;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hlen_prev;
        logic             f32;
    } fr_t;

    fr_t q, d;
    logic pcm, raw, use_dly, sig, armed, st;
    logic [CNT_W-1:0] seglen;

    always_comb begin
        pcm     = (fmt != FMT_DSP);
        raw     = pcm ? (fclk ^ alt) : fclk;
        use_dly = (fmt == FMT_I2S) || ((fmt == FMT_DSP) && !alt);
        sig     = use_dly ? q.dly : raw;
        armed   = (q.prime == 2'd2);
        st      = armed && (pcm ? (sig != q.prev) : (sig && !q.prev));
        seglen  = (q.cnt == CNT_MAX) ? q.cnt : q.cnt + 1'b1;

        d           = q;
        d.dly       = raw;
        d.prev      = sig;
        d.prime     = armed ? q.prime : q.prime + 2'd1;
        d.cnt       = st ? '0 : ((q.cnt == CNT_MAX) ? CNT_MAX : q.cnt + 1'b1);
        d.seen      = q.seen | st;
        d.hlen_prev = st ? seglen : q.hlen_prev;
        d.f32       = (st && q.seen) ? (seglen == LEN32) : q.f32;

        start     = st;
        pos       = d.cnt;
        locked    = q.seen | st;
        end_ok    = q.seen;
        end_left  = (fmt == FMT_I2S) ? !q.prev : q.prev;
        end_short = (seglen == LEN16) && (q.hlen_prev == LEN16);
        frame32   = q.f32;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/aud_rx_assembler.sv
`timescale 1ns/1ps
module aud_rx_assembler
    import aud_rx_pkg::*;
#(
    parameter int SW    = 24,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_e             fmt,
    input  logic [1:0]       wl,
    input  logic             sdata,
    input  logic             start,
    input  logic [CNT_W-1:0] pos,
    input  logic             locked,
    input  logic             end_ok,
    input  logic             end_left,
    input  logic             end_short,
    input  logic             frame32,
    output logic [SW-1:0]    left_word,
    output logic [SW-1:0]    right_word,
    output logic             word_valid
);

    localparam int IW = $clog2(SW);

    typedef struct packed {
        logic [SW-1:0] acc;
        logic [SW-1:0] accr;
        logic [SW-1:0] sh;
        logic [SW-1:0] hold;
        logic          have_left;
        logic [SW-1:0] lw;
        logic [SW-1:0] rw;
        logic          vld;
    } as_t;

    as_t q, d;

    function automatic logic [SW-1:0] top_mask(input int n);
        logic [SW-1:0] m;
        for (int i = 0; i < SW; i++) m[i] = (i >= SW - n);
        return m;
    endfunction

    function automatic logic [SW-1:0] rj_align(input logic [SW-1:0] s, input int n);
        logic [SW-1:0] o;
        for (int i = 0; i < SW; i++) begin
            if (i >= SW - n) o[i] = s[i - (SW - n)];
            else             o[i] = 1'b0;
        end
        return o;
    endfunction

    int            prog_n, n_pcm, n_dsp, p;
    logic [IW-1:0] ix;
    logic [SW-1:0] word;

    always_comb begin
        prog_n = code_to_bits(wl);
        n_pcm  = end_short ? 16 : prog_n;
        n_dsp  = frame32 ? 16 : prog_n;
        p      = int'(pos);
        ix     = '0;
        word   = '0;

        d     = q;
        d.vld = 1'b0;
        d.sh  = {q.sh[SW-2:0], sdata};

        if (fmt != FMT_DSP) begin
            if (start) d.acc = '0;
            if (p < SW) begin
                ix = IW'(SW - 1 - p);
                d.acc[ix] = sdata;
            end
            if (start && end_ok) begin
                word = (fmt == FMT_RJ) ? rj_align(q.sh, n_pcm)
                                       : (q.acc & top_mask(n_pcm));
                if (end_left) begin
                    d.hold      = word;
                    d.have_left = 1'b1;
                end else begin
                    if (q.have_left) begin
                        d.lw  = q.hold;
                        d.rw  = word;
                        d.vld = 1'b1;
                    end
                    d.have_left = 1'b0;
                end
            end
        end else begin
            if (start) begin
                d.acc  = '0;
                d.accr = '0;
            end
            if (p < n_dsp) begin
                ix = IW'(SW - 1 - p);
                d.acc[ix] = sdata;
            end else if (p < 2 * n_dsp) begin
                ix = IW'(SW - 1 - (p - n_dsp));
                d.accr[ix] = sdata;
            end
            if (locked && (p == 2 * n_dsp - 1)) begin
                d.lw  = d.acc;
                d.rw  = d.accr;
                d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign left_word  = q.lw;
    assign right_word = q.rw;
    assign word_valid = q.vld;

endmodule

// File: rtl/aud_ser_rx.sv
`timescale 1ns/1ps
module aud_ser_rx
    import aud_rx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 7
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic [5:0]          cfg,
    input  logic                fclk,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] left_word,
    output logic [SAMPLE_W-1:0] right_word,
    output logic                word_valid
);

    logic             sclk;
    fmt_e             fmt;
    logic             start, locked, end_ok, end_left, end_short, frame32;
    logic [CNT_W-1:0] pos;

    // sampling edge select: inverted clock when cfg[4] is set
    assign sclk = bclk ^ cfg[4];
    assign fmt  = fmt_e'(cfg[1:0]);

    aud_rx_framer #(.CNT_W(CNT_W)) framer_i (
        .clk       (sclk),
        .rst_n     (rst_n),
        .fmt       (fmt),
        .alt       (cfg[5]),
        .fclk      (fclk),
        .start     (start),
        .pos       (pos),
        .locked    (locked),
        .end_ok    (end_ok),
        .end_left  (end_left),
        .end_short (end_short),
        .frame32   (frame32)
    );

    aud_rx_assembler #(.SW(SAMPLE_W), .CNT_W(CNT_W)) asm_i (
        .clk        (sclk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .wl         (cfg[3:2]),
        .sdata      (sdata),
        .start      (start),
        .pos        (pos),
        .locked     (locked),
        .end_ok     (end_ok),
        .end_left   (end_left),
        .end_short  (end_short),
        .frame32    (frame32),
        .left_word  (left_word),
        .right_word (right_word),
        .word_valid (word_valid)
    );

endmodule

// File: rtl/aud_ser_rx_checker.sv
`timescale 1ns/1ps
module aud_ser_rx_checker #(
    parameter int SAMPLE_W = 24
) (
    input logic                bclk,
    input logic                rst_n,
    input logic [5:0]          cfg,
    input logic [SAMPLE_W-1:0] left_word,
    input logic [SAMPLE_W-1:0] right_word,
    input logic                word_valid
);

    logic sclk;
    assign sclk = bclk ^ cfg[4];

    // R10: the strobe never lasts two sampling cycles
    a_r10_single_strobe: assert property (@(posedge sclk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R10: words move only together with the strobe
    a_r10_words_hold: assert property (@(posedge sclk) disable iff (!rst_n)
        !word_valid |-> ($stable(left_word) && $stable(right_word)));

    // R5: 16-bit words are zero in the low byte
    a_r5_pad16: assert property (@(posedge sclk) disable iff (!rst_n)
        (word_valid && cfg[3:2] == 2'b00) |->
            (left_word[7:0] == 8'h00 && right_word[7:0] == 8'h00));

    // R5: 20-bit words are zero in the low nibble
    a_r5_pad20: assert property (@(posedge sclk) disable iff (!rst_n)
        (word_valid && cfg[3:2] == 2'b01) |->
            (left_word[3:0] == 4'h0 && right_word[3:0] == 4'h0));

endmodule

bind aud_ser_rx aud_ser_rx_checker #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .left_word  (left_word),
    .right_word (right_word),
    .word_valid (word_valid)
);

// File: tb/aud_ser_rx_tb_top.sv
`timescale 1ns/1ps
module aud_ser_rx_tb_top;

    logic        bclk = 1'b0;
    logic        rst_n;
    logic [5:0]  cfg;
    logic        fclk, sdata;
    logic [23:0] left_word, right_word;
    logic        word_valid;

    always #2 bclk = ~bclk;   // 250 MHz

    aud_ser_rx dut_i (
        .bclk(bclk), .rst_n(rst_n), .cfg(cfg), .fclk(fclk), .sdata(sdata),
        .left_word(left_word), .right_word(right_word), .word_valid(word_valid)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [23:0] txl [0:7];
    logic [23:0] txr [0:7];
    logic [23:0] rxl [0:63];
    logic [23:0] rxr [0:63];
    int nrx;
    bit prev_v, pulse_bad;
    logic fv [0:140];
    logic dv [0:140];
    logic carry;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] msk(input int n);
        return 24'hFFFFFF << (24 - n);
    endfunction

    // wait for the edge the port does not sample on, observe, then drive
    task automatic drive_slot(input logic f, input logic d);
        if (cfg[4]) @(posedge bclk); else @(negedge bclk);
        if (word_valid) begin
            if (prev_v) pulse_bad = 1;
            if (nrx < 64) begin
                rxl[nrx] = left_word;
                rxr[nrx] = right_word;
            end
            nrx++;
        end
        prev_v = word_valid;
        fclk  = f;
        sdata = d;
    endtask

    task automatic do_reset(input logic [5:0] c);
        rst_n = 0; cfg = c; fclk = 0; sdata = 0;
        repeat (3) @(negedge bclk);
        #1 rst_n = 1;
        nrx = 0; prev_v = 0; pulse_bad = 0; carry = 0;
        repeat (4) drive_slot(1'b0, 1'b0);
    endtask

    // fmt: 0 RJ, 1 LJ, 2 I2S, 3 DSP; h: half length (DSP: half the frame)
    task automatic run_stream(input int fmt, input logic alt, input int h,
                              input int nt, input int neff, input int k_n,
                              input string req);
        int frm;
        logic [23:0] el, er, pl, pr;
        bit found;
        for (int k = 0; k < k_n; k++) begin
            txl[k] = 24'hA53C96 ^ (24'h1B3D7F * 24'(k + 1));
            txr[k] = 24'h3E81C5 ^ (24'h27F4A9 * 24'(k + 3));
        end
        for (int k = 0; k <= k_n; k++) begin
            frm = (k < k_n) ? k : k_n - 1;
            for (int s = 0; s <= 2 * h; s++) begin fv[s] = 0; dv[s] = 0; end
            if (fmt == 3) begin
                int base = alt ? 0 : 1;
                fv[0] = 1;
                for (int i = 0; i < nt; i++) begin
                    dv[base + i]      = txl[frm][23 - i];
                    dv[base + nt + i] = txr[frm][23 - i];
                end
            end else begin
                logic fl = ((fmt == 2) ? 1'b0 : 1'b1) ^ alt;
                int base = (fmt == 2) ? 1 : ((fmt == 0) ? h - nt : 0);
                for (int s = 0; s < 2 * h; s++) fv[s] = (s < h) ? fl : !fl;
                for (int i = 0; i < nt; i++) begin
                    dv[base + i]     = txl[frm][23 - i];
                    dv[h + base + i] = txr[frm][23 - i];
                end
            end
            dv[0] = dv[0] | carry;
            for (int s = 0; s < 2 * h; s++) drive_slot(fv[s], dv[s]);
            carry = dv[2 * h];
        end
        repeat (2) drive_slot(1'b0, 1'b0);

        el = txl[k_n - 1] & msk(neff); er = txr[k_n - 1] & msk(neff);
        pl = txl[k_n - 2] & msk(neff); pr = txr[k_n - 2] & msk(neff);
        check(nrx >= k_n - 1, "R10", {req, " strobe count"}, 24'(nrx), 24'(k_n - 1));
        check(!pulse_bad, "R10", {req, " strobe width"}, 24'(pulse_bad), 24'h0);
        if (nrx >= 1 && nrx <= 64) begin
            check(rxl[nrx - 1] == el, req, "last left", rxl[nrx - 1], el);
            check(rxr[nrx - 1] == er, req, "last right", rxr[nrx - 1], er);
        end else begin
            check(0, req, "no pair captured", 24'(nrx), 24'(k_n));
        end
        found = 0;
        for (int i = 0; i < nrx && i < 64; i++)
            if (rxl[i] == pl && rxr[i] == pr) found = 1;
        check(found, req, "earlier pair present", 24'(found), 24'h1);
    endtask

    task automatic t_reset();
        rst_n = 0; cfg = 6'b00_01_10; fclk = 0; sdata = 0;
        repeat (2) @(negedge bclk);
        check(left_word == 0 && right_word == 0, "R11", "words in reset", left_word, 24'h0);
        check(word_valid == 0, "R11", "strobe in reset", 24'(word_valid), 24'h0);
        do_reset(6'b00_01_10);
        check(left_word == 0 && right_word == 0, "R11", "words after reset", right_word, 24'h0);
    endtask

    task automatic t_i2s();
        do_reset(6'b00_10_10); run_stream(2, 0, 32, 24, 24, 5, "R1");
        do_reset(6'b00_11_10); run_stream(2, 0, 24, 24, 24, 5, "R9");
    endtask

    task automatic t_lj();
        do_reset(6'b00_01_01); run_stream(1, 0, 32, 20, 20, 5, "R2");
        do_reset(6'b10_01_01); run_stream(1, 1, 32, 20, 20, 5, "R7");
    endtask

    task automatic t_rj();
        do_reset(6'b00_00_00); run_stream(0, 0, 32, 16, 16, 5, "R3");
        do_reset(6'b00_11_00); run_stream(0, 0, 32, 24, 24, 5, "R5");
        do_reset(6'b10_10_00); run_stream(0, 1, 32, 24, 24, 5, "R7");
    endtask

    task automatic t_dsp();
        do_reset(6'b00_10_11); run_stream(3, 0, 32, 24, 24, 5, "R4");
        do_reset(6'b10_01_11); run_stream(3, 1, 32, 20, 20, 5, "R4");
    endtask

    task automatic t_auto32();
        do_reset(6'b00_10_10); run_stream(2, 0, 16, 16, 16, 5, "R8");
        do_reset(6'b00_01_01); run_stream(1, 0, 16, 16, 16, 5, "R8");
        do_reset(6'b10_10_11); run_stream(3, 1, 16, 16, 16, 5, "R8");
    endtask

    task automatic t_edge();
        do_reset(6'b01_10_01); run_stream(1, 0, 32, 24, 24, 5, "R6");
        do_reset(6'b01_00_10); run_stream(2, 0, 32, 16, 16, 5, "R6");
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_i2s();
        t_lj();
        t_rj();
        t_dsp();
        t_auto32();
        t_edge();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule